// File: doc/BRIEF.md
# Square-Root Carry Select Adder

A purely combinational 16-bit adder that adds two operands and a carry-in and produces a 16-bit sum and a carry-out. The word is cut into five slices of growing width (2, 2, 3, 4 and 5 bits, from the least significant end). The bottom slice is an ordinary ripple adder fed by the external carry-in.

Each upper slice ripples its operands only once, assuming a slice carry-in of zero. An increment-by-one converter then forms the carry-in-of-one result from that partial sum and partial carry. The carry arriving from the slice below picks one of the two results. It is used as a datapath element wherever a short, wide add is needed within one clock period.

The carries between slices are brought out as observation ports, so that the selection chain can be checked on its own.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {carry_out, sum_o} equals opa + opb + carry_in as an unsigned 17-bit value.
- R2: grp_c1 equals bit 2 of opa[1:0] + opb[1:0] + carry_in, which is the carry out of the bottom 2-bit slice.
- R3: grp_c3 equals bit 4 of opa[3:0] + opb[3:0] + carry_in, which is the carry out of the slice covering bits 3..2.
- R4: grp_c6 equals bit 7 of opa[6:0] + opb[6:0] + carry_in, which is the carry out of the slice covering bits 6..4.
- R5: grp_c10 equals bit 11 of opa[10:0] + opb[10:0] + carry_in, which is the carry out of the slice covering bits 10..7.
- R6: When opa XOR opb is all ones and carry_in is 1, the carry ripples across every slice. In that case sum_o is 0, and carry_out and all four slice carries are 1.
- R7: With both operands 0 and carry_in 0, sum_o, carry_out and all slice carries are 0.
- R8: Bits of sum_o below a slice boundary do not depend on operand bits above it. Changing opa[15:7] and opb[15:7] leaves sum_o[6:0] and grp_c6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_c1 | output | 1 | Carry out of bits 1..0 |
| grp_c3 | output | 1 | Carry out of bits 3..2 |
| grp_c6 | output | 1 | Carry out of bits 6..4 |
| grp_c10 | output | 1 | Carry out of bits 10..7 |

## Verification
Every output of this block has zero cycles of latency. Sum, carry-out and the four slice carries all settle in the same cycle in which the operands change. The bench therefore drives new operands just after a rising edge and reads every output at the following falling edge, half a period later. Each vector is thus compared only after the whole select chain has settled and before the next vector is driven.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int DATA_W  = 16;
  localparam int NUM_GRP = 5;
  localparam int GRP_W [NUM_GRP] = '{2, 2, 3, 4, 5};

  // Least significant bit position of slice g.
  function automatic int grp_lo(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += GRP_W[i];
    return acc;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int W        = 2,
  parameter bit ZERO_CIN = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] cy;

  assign cy[0] = ZERO_CIN ? 1'b0 : ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (ZERO_CIN && i == 0) begin : g_half
      // carry-in known zero: half adder
      assign s[i]    = a[i] ^ b[i];
      assign cy[i+1] = a[i] & b[i];
    end else begin : g_full
      assign s[i]    = a[i] ^ b[i] ^ cy[i];
      assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end
  end

  assign co = cy[W];
endmodule

// File: rtl/csa_incr.sv
module csa_incr #(
  parameter int W = 3
) (
  input  logic [W-1:0] v,
  output logic [W-1:0] x
);
  // all_low[k] = AND of v[k-1:0]; all_low[0] = 1
  logic [W-1:0] all_low;

  assign all_low[0] = 1'b1;
  for (genvar k = 1; k < W; k++) begin : g_chain
    assign all_low[k] = all_low[k-1] & v[k-1];
  end

  for (genvar k = 0; k < W; k++) begin : g_out
    assign x[k] = v[k] ^ all_low[k];
  end
endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int W = 3
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sel,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] ps;
  logic         pc;
  logic [W:0]   plus1;

  csa_ripple #(.W(W), .ZERO_CIN(1'b1)) u_rip (
    .a (a),
    .b (b),
    .ci(1'b0),
    .s (ps),
    .co(pc)
  );

  csa_incr #(.W(W + 1)) u_inc (
    .v({pc, ps}),
    .x(plus1)
  );

  always_comb begin
    if (sel) {co, s} = plus1;
    else     {co, s} = {pc, ps};
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder
  import csa_pkg::*;
(
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              carry_in,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_out,
  output logic              grp_c1,
  output logic              grp_c3,
  output logic              grp_c6,
  output logic              grp_c10
);
  logic [NUM_GRP:0] gc;

  assign gc[0] = carry_in;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
    localparam int LO = grp_lo(g);
    localparam int W  = GRP_W[g];
    if (g == 0) begin : g_base
      csa_ripple #(.W(W), .ZERO_CIN(1'b0)) u_base (
        .a (opa[LO +: W]),
        .b (opb[LO +: W]),
        .ci(gc[g]),
        .s (sum_o[LO +: W]),
        .co(gc[g+1])
      );
    end else begin : g_sel
      csa_group #(.W(W)) u_grp (
        .a  (opa[LO +: W]),
        .b  (opb[LO +: W]),
        .sel(gc[g]),
        .s  (sum_o[LO +: W]),
        .co (gc[g+1])
      );
    end
  end

  assign grp_c1    = gc[1];
  assign grp_c3    = gc[2];
  assign grp_c6    = gc[3];
  assign grp_c10   = gc[4];
  assign carry_out = gc[NUM_GRP];
endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk
  import csa_pkg::*;
(
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              carry_in,
  input logic [DATA_W-1:0] sum_o,
  input logic              carry_out,
  input logic              grp_c1,
  input logic              grp_c3,
  input logic              grp_c6,
  input logic              grp_c10
);
  logic [DATA_W:0] full;
  logic [2:0]      p1;
  logic [4:0]      p3;
  logic [7:0]      p6;
  logic [11:0]     p10;

  always_comb begin
    full = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, carry_in};
    p1   = {1'b0, opa[1:0]}  + {1'b0, opb[1:0]}  + {2'b0, carry_in};
    p3   = {1'b0, opa[3:0]}  + {1'b0, opb[3:0]}  + {4'b0, carry_in};
    p6   = {1'b0, opa[6:0]}  + {1'b0, opb[6:0]}  + {7'b0, carry_in};
    p10  = {1'b0, opa[10:0]} + {1'b0, opb[10:0]} + {11'b0, carry_in};
  end

  always_comb begin
    if (!$isunknown({opa, opb, carry_in})) begin
      assert_total_R1: assert ({carry_out, sum_o} == full);
      assert_c1_R2:    assert (grp_c1 == p1[2]);
      assert_c3_R3:    assert (grp_c3 == p3[4]);
      assert_c6_R4:    assert (grp_c6 == p6[7]);
      assert_c10_R5:   assert (grp_c10 == p10[11]);
      if (&(opa ^ opb) && carry_in) begin
        assert_ripple_R6: assert (sum_o == '0 && carry_out &&
                                  grp_c1 && grp_c3 && grp_c6 && grp_c10);
      end
      if (opa == '0 && opb == '0 && !carry_in) begin
        assert_zero_R7: assert (sum_o == '0 && !carry_out &&
                                !grp_c1 && !grp_c3 && !grp_c6 && !grp_c10);
      end
    end
  end
endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk u_chk (.*);

// File: tb/sim_sqrt_csel_adder.sv
`timescale 1ns/1ps
module sim_sqrt_csel_adder;
  localparam time TCK = 8ns;

  logic        clk;
  logic        rst_n;
  logic [15:0] opa, opb;
  logic        carry_in;
  logic [15:0] sum_o;
  logic        carry_out, grp_c1, grp_c3, grp_c6, grp_c10;

  int checks;
  int errors;
  bit done;

  sqrt_csel_adder u0 (
    .opa(opa), .opb(opb), .carry_in(carry_in),
    .sum_o(sum_o), .carry_out(carry_out),
    .grp_c1(grp_c1), .grp_c3(grp_c3), .grp_c6(grp_c6), .grp_c10(grp_c10)
  );

  initial clk = 1'b0;
  always #(TCK/2) clk = ~clk;

  // {opa, opb, carry_in, exp carry_out, exp sum}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'h0000},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF},
    {16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF},
    {16'hAAAA, 16'h5555, 1'b1, 1'b1, 16'h0000},
    {16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555},
    {16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000},
    {16'h0003, 16'h0001, 1'b0, 1'b0, 16'h0004},
    {16'h00FF, 16'h0001, 1'b1, 1'b0, 16'h0101},
    {16'h7FFF, 16'h0000, 1'b1, 1'b0, 16'h8000},
    {16'h07FF, 16'h0001, 1'b0, 1'b0, 16'h0800},
    {16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0001}
  };

  function automatic logic carry_at(input logic [15:0] a, input logic [15:0] b,
                                    input logic ci, input int hi);
    logic [16:0] m, t;
    m = (17'd1 << (hi + 1)) - 17'd1;
    t = ({1'b0, a} & m) + ({1'b0, b} & m) + {16'b0, ci};
    return t[hi+1];
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (opa=%h opb=%h cin=%b)",
               req, act, exp, opa, opb, carry_in);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic ci);
    @(posedge clk);
    #1;
    opa = a; opb = b; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic check_all(input logic [16:0] exp_total);
    chk("R1 total", {carry_out, sum_o}, exp_total);
    chk("R2 c1",  {16'b0, grp_c1},  {16'b0, carry_at(opa, opb, carry_in, 1)});
    chk("R3 c3",  {16'b0, grp_c3},  {16'b0, carry_at(opa, opb, carry_in, 3)});
    chk("R4 c6",  {16'b0, grp_c6},  {16'b0, carry_at(opa, opb, carry_in, 6)});
    chk("R5 c10", {16'b0, grp_c10}, {16'b0, carry_at(opa, opb, carry_in, 10)});
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    opa = '0; opb = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R7: quiescent zero state
    drive(16'h0000, 16'h0000, 1'b0);
    chk("R7 zero", {grp_c10, grp_c6, grp_c3, grp_c1, carry_out, sum_o}, 21'h0);

    // vector table (R1..R5)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      check_all(VEC[i][16:0]);
    end

    // R6: full propagation from bit 0
    drive(16'hFFFF, 16'h0000, 1'b1);
    chk("R6 ripple", {carry_out, sum_o}, 17'h1_0000);
    chk("R6 carries", {13'b0, grp_c10, grp_c6, grp_c3, grp_c1}, 17'h0000F);
    drive(16'hF0F0, 16'h0F0F, 1'b1);
    chk("R6 ripple mixed", {carry_out, grp_c10, grp_c6, grp_c3, grp_c1, sum_o},
        {5'b11111, 16'h0000});

    // R8: upper operand bits do not disturb lower slices
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, b;
      logic        ci;
      logic [7:0]  low_ref;
      a = 16'($urandom); b = 16'($urandom); ci = 1'($urandom);
      drive(a, b, ci);
      low_ref = {grp_c6, sum_o[6:0]};
      drive({16'($urandom) & 16'hFF80} | (a & 16'h007F),
            {16'($urandom) & 16'hFF80} | (b & 16'h007F), ci);
      chk("R8 low slices", {9'b0, grp_c6, sum_o[6:0]}, {9'b0, low_ref});
    end

    // random sweep (R1..R5)
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] a, b;
      logic        ci;
      a = 16'($urandom); b = 16'($urandom); ci = 1'($urandom);
      drive(a, b, ci);
      check_all({1'b0, a} + {1'b0, b} + {16'b0, ci});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule